// File: doc/BRIEF.md
# Flash Line Fetch Accelerator

This block sits between a core's 32-bit fetch port and a slow flash array that returns a full 128-bit line per read. It keeps three single-line buffers, one per traffic class. The prefetch buffer serves instruction fetches that follow in address order. The branch trail buffer catches instruction fetches that jump. The data buffer serves data reads. A fetch that finds its line in the right buffer is answered in the cycle it is presented. A fetch that misses stalls the core while the block reads the whole line from flash. The read is held for a programmable number of cycles, and the line then goes into the buffer for that traffic class.

Two configuration registers steer the block. The control register turns acceleration on only when it holds the enable code 2. When acceleration is off, every access goes to flash with the longest access time, and the buffers are neither consulted nor filled. The timing register sets how many cycles a buffered-mode flash read lasts. The expected software sequence is: disable, write the timing value, enable again. Every control write clears all three buffers.

The state machine has two states. `ST_IDLE` decodes a request and answers hits. `ST_READ` holds the flash read and counts cycles. The transition `IDLE->READ` happens on a request that cannot be served from a buffer. The transition `READ->IDLE` happens in the last counted cycle, when the word is returned straight from the flash data and the line is written into its buffer. Any other case keeps the current state.

Top module: `fetch_accel`

## Requirements
- R1: After reset, acceleration is off, the timing register holds 7, and `rsp_valid` and `fl_req` are low.
- R2: While acceleration is off, every access stalls exactly 7 cycles whatever the timing register holds, and repeating an address never makes it faster.
- R3: Only control value 2 turns acceleration on. Values 0, 1 and 3 all act as off.
- R4: A timing write of 1 to 7 sets the buffered-mode miss stall to that many cycles. A timing write of 0 is ignored and the old value stays.
- R5: An instruction fetch at the previous instruction address plus 4 is sequential. It is answered in its own cycle (zero stall) when the prefetch buffer or the branch trail buffer holds its line, where the line is address bits 31:4.
- R6: A sequential instruction fetch that misses stalls for the timing value and loads the whole line into the prefetch buffer, so the other words of that line then hit.
- R7: Any other instruction fetch, including the first one after reset, is a branch. It is checked against the branch trail buffer only and refills that buffer on a miss. A branch to a line held only in the prefetch buffer misses.
- R8: Data reads use only the data buffer: a hit has zero stall and a miss refills that buffer. Data reads neither consult nor change the instruction buffers, and they do not change the sequential-order history.
- R9: Any control register write, including rewriting 2, empties all three buffers.
- R10: A response appears only while a request is held. Its data is word bits 3:2 of the line, and flash word i of line L reads as {L, i, 2'b00} XOR 0x5A5A0F0F in the bench model.
- R11: On a miss, `fl_req` is low in the request cycle and then high for exactly the stall cycles. `fl_addr` holds the line address and stays stable throughout, and `fl_req` drops in the cycle after the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 2 | Control value (2 = acceleration on) |
| tim_we | input | 1 | Timing register write strobe |
| tim_wdata | input | 3 | Flash read length in cycles, 1 to 7 |
| req_valid | input | 1 | Core request, held until `rsp_valid` |
| req_instr | input | 1 | 1 = instruction fetch, 0 = data read |
| req_addr | input | 32 | Word-aligned byte address |
| rsp_valid | output | 1 | Response strobe for the held request |
| rsp_data | output | 32 | Returned word |
| fl_req | output | 1 | Flash line read in progress |
| fl_addr | output | 28 | Flash line address (byte address bits 31:4) |
| fl_rdata | input | 128 | Flash line data, word 0 in bits 31:0 |

## Verification
The bench sweeps every timing value from 1 to 7 over a loop program of ten sequential instruction words, with data reads mixed in. Three passes through the loop separate first-pass misses from later hits in the branch trail buffer and from repeated prefetch refills. A jump to a line held only in the prefetch buffer, and a data read of an instruction line, show that the three buffers stay apart. Control values 0 to 3 and a zero timing write are swept to separate the one enable code and the ignored write. Invalidation is shown by refetching lines just after a control rewrite.

// File: rtl/fa_pkg.sv
package fa_pkg;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned LINE_WORDS = 4;
    localparam int unsigned LINE_W     = WORD_W * LINE_WORDS;
    localparam int unsigned WOFF_W     = $clog2(LINE_WORDS);
    localparam int unsigned BYTE_W     = $clog2(WORD_W / 8);
    localparam int unsigned TAG_LO     = BYTE_W + WOFF_W;
    localparam int unsigned NUM_BUFS   = 3;

    typedef enum logic [1:0] {
        BUF_PF = 2'd0,
        BUF_BT = 2'd1,
        BUF_DB = 2'd2
    } buf_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_READ = 1'b1
    } fa_state_e;

    function automatic logic [WORD_W-1:0] pick_word(input logic [LINE_W-1:0] line,
                                                    input logic [WOFF_W-1:0] off);
        return line[off*WORD_W +: WORD_W];
    endfunction
endpackage

// File: rtl/fa_cfg_regs.sv
module fa_cfg_regs #(
    parameter int unsigned CTL_W     = 2,
    parameter int unsigned TIM_W     = 3,
    parameter int unsigned TIM_RESET = 7,
    parameter logic [CTL_W-1:0] EN_CODE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             tim_we,
    input  logic [TIM_W-1:0] tim_wdata,
    output logic             acc_en,
    output logic [TIM_W-1:0] tim,
    output logic             inval
);
    logic [CTL_W-1:0] ctl_q;
    logic [TIM_W-1:0] tim_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            tim_q <= TIM_W'(TIM_RESET);
        end else begin
            if (ctl_we) begin
                ctl_q <= ctl_wdata;
            end
            // zero is not a legal access length: keep the old value
            if (tim_we && (tim_wdata != '0)) begin
                tim_q <= tim_wdata;
            end
        end
    end

    assign acc_en = (ctl_q == EN_CODE);
    assign tim    = tim_q;
    assign inval  = ctl_we;
endmodule

// File: rtl/fa_line_buf.sv
module fa_line_buf
    import fa_pkg::*;
#(
    parameter int unsigned TAG_W = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inval,
    input  logic              fill_en,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [LINE_W-1:0] fill_line,
    input  logic [TAG_W-1:0]  look_tag,
    output logic              hit,
    output logic [LINE_W-1:0] line
);
    logic              valid_q;
    logic [TAG_W-1:0]  tag_q;
    logic [LINE_W-1:0] line_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else if (inval) begin
            valid_q <= 1'b0;
        end else if (fill_en) begin
            valid_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q  <= '0;
            line_q <= '0;
        end else if (fill_en && !inval) begin
            tag_q  <= fill_tag;
            line_q <= fill_line;
        end
    end

    assign hit  = valid_q && (tag_q == look_tag);
    assign line = line_q;
endmodule

// File: rtl/fa_seq_track.sv
module fa_seq_track #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic [ADDR_W-1:0] cur_addr,
    output logic              is_seq
);
    logic [ADDR_W-1:0] last_q;
    logic              last_v_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q   <= '0;
            last_v_q <= 1'b0;
        end else if (upd) begin
            last_q   <= cur_addr;
            last_v_q <= 1'b1;
        end
    end

    assign is_seq = last_v_q && (cur_addr == last_q + ADDR_W'(STEP));
endmodule

// File: rtl/fa_ctrl.sv
module fa_ctrl
    import fa_pkg::*;
#(
    parameter int unsigned TAG_W   = 28,
    parameter int unsigned TIM_W   = 3,
    parameter int unsigned TIM_MAX = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              acc_en,
    input  logic              hit,
    input  logic              inval,
    input  logic [TIM_W-1:0]  tim,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [WOFF_W-1:0] req_off,
    input  buf_sel_e          sel_in,
    output logic              fl_req,
    output logic [TAG_W-1:0]  fl_tag,
    output logic [WOFF_W-1:0] off_q,
    output buf_sel_e          sel_q,
    output logic              rsp_buf,
    output logic              rsp_fl,
    output logic              fill_fire
);
    fa_state_e        state_q, state_d;
    logic [TIM_W-1:0] cnt_q, lim_q;
    logic [TAG_W-1:0] tag_q;
    logic             fill_ok_q;
    logic             start, last;

    assign start = (state_q == ST_IDLE) && req_valid && !(acc_en && hit);
    assign last  = (state_q == ST_READ) && (cnt_q >= lim_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_READ;
            ST_READ: if (last)  state_d = ST_IDLE;
        endcase
    end

    // read bookkeeping captured at the miss
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            lim_q     <= TIM_W'(TIM_MAX);
            tag_q     <= '0;
            off_q     <= '0;
            sel_q     <= BUF_PF;
            fill_ok_q <= 1'b0;
        end else if (start) begin
            cnt_q     <= TIM_W'(1);
            lim_q     <= acc_en ? tim : TIM_W'(TIM_MAX);
            tag_q     <= req_tag;
            off_q     <= req_off;
            sel_q     <= sel_in;
            fill_ok_q <= acc_en;
        end else if (state_q == ST_READ) begin
            if (!last) begin
                cnt_q <= cnt_q + TIM_W'(1);
            end
            if (inval) begin
                fill_ok_q <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        fl_req    = 1'b0;
        rsp_buf   = 1'b0;
        rsp_fl    = 1'b0;
        fill_fire = 1'b0;
        unique case (state_q)
            ST_IDLE: rsp_buf = req_valid && acc_en && hit;
            ST_READ: begin
                fl_req    = 1'b1;
                rsp_fl    = last;
                fill_fire = last && fill_ok_q && acc_en && !inval;
            end
        endcase
    end

    assign fl_tag = tag_q;
endmodule

// File: rtl/fetch_accel.sv
module fetch_accel
    import fa_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned CTL_W   = 2,
    parameter int unsigned TIM_W   = 3,
    parameter int unsigned TIM_MAX = 7,
    parameter logic [CTL_W-1:0] EN_CODE = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ctl_we,
    input  logic [CTL_W-1:0]         ctl_wdata,
    input  logic                     tim_we,
    input  logic [TIM_W-1:0]         tim_wdata,
    input  logic                     req_valid,
    input  logic                     req_instr,
    input  logic [ADDR_W-1:0]        req_addr,
    output logic                     rsp_valid,
    output logic [WORD_W-1:0]        rsp_data,
    output logic                     fl_req,
    output logic [ADDR_W-TAG_LO-1:0] fl_addr,
    input  logic [LINE_W-1:0]        fl_rdata
);
    localparam int unsigned TAG_W = ADDR_W - TAG_LO;

    logic              acc_en, inval, is_seq, hit;
    logic [TIM_W-1:0]  tim_cur;
    logic [TAG_W-1:0]  req_tag;
    logic [WOFF_W-1:0] req_off, off_q;
    buf_sel_e          sel_in, sel_q;
    logic              rsp_buf, rsp_fl, fill_fire;
    logic [LINE_W-1:0] hit_line;
    logic              hit_v  [NUM_BUFS];
    logic [LINE_W-1:0] line_v [NUM_BUFS];

    assign req_tag = req_addr[ADDR_W-1:TAG_LO];
    assign req_off = req_addr[TAG_LO-1:BYTE_W];

    fa_cfg_regs #(
        .CTL_W(CTL_W), .TIM_W(TIM_W), .TIM_RESET(TIM_MAX), .EN_CODE(EN_CODE)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .tim_we(tim_we), .tim_wdata(tim_wdata),
        .acc_en(acc_en), .tim(tim_cur), .inval(inval)
    );

    fa_seq_track #(.ADDR_W(ADDR_W), .STEP(WORD_W / 8)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .upd(rsp_valid && req_instr),
        .cur_addr(req_addr),
        .is_seq(is_seq)
    );

    generate
        for (genvar b = 0; b < NUM_BUFS; b++) begin : g_buf
            fa_line_buf #(.TAG_W(TAG_W)) u_buf (
                .clk(clk), .rst_n(rst_n),
                .inval(inval),
                .fill_en(fill_fire && (int'(sel_q) == b)),
                .fill_tag(fl_addr),
                .fill_line(fl_rdata),
                .look_tag(req_tag),
                .hit(hit_v[b]),
                .line(line_v[b])
            );
        end
    endgenerate

    // route the request to its buffer class
    always_comb begin
        sel_in   = BUF_DB;
        hit      = hit_v[int'(BUF_DB)];
        hit_line = line_v[int'(BUF_DB)];
        if (req_instr) begin
            if (is_seq) begin
                sel_in = BUF_PF;
                if (hit_v[int'(BUF_PF)]) begin
                    hit      = 1'b1;
                    hit_line = line_v[int'(BUF_PF)];
                end else begin
                    hit      = hit_v[int'(BUF_BT)];
                    hit_line = line_v[int'(BUF_BT)];
                end
            end else begin
                sel_in   = BUF_BT;
                hit      = hit_v[int'(BUF_BT)];
                hit_line = line_v[int'(BUF_BT)];
            end
        end
    end

    fa_ctrl #(.TAG_W(TAG_W), .TIM_W(TIM_W), .TIM_MAX(TIM_MAX)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .acc_en(acc_en), .hit(hit), .inval(inval),
        .tim(tim_cur), .req_tag(req_tag), .req_off(req_off), .sel_in(sel_in),
        .fl_req(fl_req), .fl_tag(fl_addr), .off_q(off_q), .sel_q(sel_q),
        .rsp_buf(rsp_buf), .rsp_fl(rsp_fl), .fill_fire(fill_fire)
    );

    assign rsp_valid = rsp_buf || rsp_fl;
    assign rsp_data  = rsp_buf ? pick_word(hit_line, req_off)
                               : pick_word(fl_rdata, off_q);
endmodule

// File: rtl/fa_checker.sv
module fa_checker #(
    parameter int unsigned LA_W  = 28,
    parameter int unsigned TIM_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             rsp_valid,
    input logic             fl_req,
    input logic [LA_W-1:0]  fl_addr,
    input logic             acc_en,
    input logic [TIM_W-1:0] tim
);
    AST_FLASH_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && !rsp_valid) |=> (fl_req && $stable(fl_addr))); // R11

    AST_READ_ENDS_AT_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && rsp_valid) |=> !fl_req); // R11

    AST_NO_READ_UNASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && !fl_req) |=> !fl_req); // R11

    AST_RSP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_valid); // R10

    AST_OFF_NO_FAST_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_en && req_valid && !fl_req) |-> !rsp_valid); // R2

    AST_READ_AFTER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_req) |-> ($past(req_valid) && !$past(rsp_valid))); // R6

    AST_TIM_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        tim != '0); // R4
endmodule

bind fetch_accel fa_checker #(.LA_W(ADDR_W - 4), .TIM_W(TIM_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_valid(rsp_valid),
    .fl_req(fl_req), .fl_addr(fl_addr), .acc_en(acc_en), .tim(tim_cur)
);

// File: tb/fetch_accel_tb_top.sv
module fetch_accel_tb_top;
    localparam logic [31:0] SALT = 32'h5A5A_0F0F;
    localparam int FULL_STALL = 7;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         ctl_we;
    logic [1:0]   ctl_wdata;
    logic         tim_we;
    logic [2:0]   tim_wdata;
    logic         req_valid;
    logic         req_instr;
    logic [31:0]  req_addr;
    logic         rsp_valid;
    logic [31:0]  rsp_data;
    logic         fl_req;
    logic [27:0]  fl_addr;
    logic [127:0] fl_rdata;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    // reference model state
    bit          m_en;
    int          m_tim;
    bit          m_v   [3];
    logic [27:0] m_tag [3];
    bit          m_lv;
    logic [31:0] m_last;

    always #4 clk = ~clk;

    generate
        for (genvar i = 0; i < 4; i++) begin : g_flash
            assign fl_rdata[i*32 +: 32] = {fl_addr, 2'(i), 2'b00} ^ SALT;
        end
    endgenerate

    fetch_accel dut_i (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .tim_we(tim_we), .tim_wdata(tim_wdata),
        .req_valid(req_valid), .req_instr(req_instr), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .fl_req(fl_req), .fl_addr(fl_addr), .fl_rdata(fl_rdata)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_err++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 100000);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    function automatic int model_access(input bit instr, input logic [31:0] a,
                                        output string rq);
        logic [27:0] ln;
        bit seq;
        bit hit;
        int sel;
        int st;
        ln  = a[31:4];
        hit = 1'b0;
        sel = 2;
        st  = FULL_STALL;
        rq  = "R2";
        if (m_en) begin
            if (instr) begin
                seq = m_lv && (a == m_last + 32'd4);
                if (seq) begin
                    hit = (m_v[0] && m_tag[0] == ln) || (m_v[1] && m_tag[1] == ln);
                    sel = 0;
                    rq  = hit ? "R5" : "R6";
                end else begin
                    hit = m_v[1] && m_tag[1] == ln;
                    sel = 1;
                    rq  = "R7";
                end
            end else begin
                hit = m_v[2] && m_tag[2] == ln;
                sel = 2;
                rq  = "R8";
            end
            if (hit) begin
                st = 0;
            end else begin
                st = m_tim;
                m_v[sel]   = 1'b1;
                m_tag[sel] = ln;
            end
        end
        if (instr) begin
            m_lv   = 1'b1;
            m_last = a;
        end
        return st;
    endfunction

    task automatic do_access(input bit instr, input logic [31:0] a, input string tag);
        int    exp_st;
        int    st;
        bit    fl_ok;
        string rq;
        exp_st = model_access(instr, a, rq);
        if (tag != "") rq = tag;
        @(negedge clk);
        req_valid = 1'b1;
        req_instr = instr;
        req_addr  = a;
        st    = 0;
        fl_ok = 1'b1;
        #1;
        if (fl_req) fl_ok = 1'b0;
        while (!rsp_valid && st < 40) begin
            @(negedge clk);
            #1;
            st++;
            if (!fl_req || fl_addr != a[31:4]) fl_ok = 1'b0;
        end
        chk(st == exp_st, rq, "stall cycles", 64'(st), 64'(exp_st));
        chk(rsp_data == ({a[31:2], 2'b00} ^ SALT), "R10", "returned word",
            64'(rsp_data), 64'({a[31:2], 2'b00} ^ SALT));
        if (exp_st > 0) fl_ok = fl_ok && fl_req;
        else            fl_ok = fl_ok && !fl_req;
        chk(fl_ok, "R11", "flash read window", 64'(fl_ok), 64'd1);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic write_ctl(input logic [1:0] v);
        m_en = (v == 2'd2);
        for (int b = 0; b < 3; b++) m_v[b] = 1'b0;
        @(negedge clk);
        ctl_we    = 1'b1;
        ctl_wdata = v;
        @(negedge clk);
        ctl_we    = 1'b0;
    endtask

    task automatic write_tim(input logic [2:0] v);
        if (v != 3'd0) m_tim = int'(v);
        @(negedge clk);
        tim_we    = 1'b1;
        tim_wdata = v;
        @(negedge clk);
        tim_we    = 1'b0;
    endtask

    initial begin
        logic [31:0] base;
        rst_n     = 1'b0;
        ctl_we    = 1'b0;
        ctl_wdata = '0;
        tim_we    = 1'b0;
        tim_wdata = '0;
        req_valid = 1'b0;
        req_instr = 1'b0;
        req_addr  = '0;
        m_en   = 1'b0;
        m_tim  = 7;
        m_lv   = 1'b0;
        m_last = '0;
        for (int b = 0; b < 3; b++) begin
            m_v[b]   = 1'b0;
            m_tag[b] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1: quiet outputs after reset
        chk(!rsp_valid, "R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
        chk(!fl_req, "R1", "fl_req after reset", 64'(fl_req), 64'd0);
        // R1: off after reset, then default timing 7 once enabled
        do_access(1'b1, 32'h0000_0200, "R1");
        write_ctl(2'd2);
        do_access(1'b1, 32'h0000_0200, "R1");

        // R2: off ignores timing and buffers
        write_ctl(2'd0);
        write_tim(3'd1);
        do_access(1'b1, 32'h0000_0200, "R2");
        do_access(1'b1, 32'h0000_0204, "R2");
        do_access(1'b1, 32'h0000_0204, "R2");
        do_access(1'b0, 32'h0000_0200, "R2");
        do_access(1'b0, 32'h0000_0200, "R2");

        // R3: only code 2 enables
        for (int v = 0; v < 4; v++) begin
            write_ctl(2'(v));
            write_tim(3'd2);
            do_access(1'b1, 32'h0000_0300, "R3");
            do_access(1'b1, 32'h0000_0300, "R3");
        end

        // R4: zero timing write ignored
        write_ctl(2'd2);
        write_tim(3'd3);
        write_tim(3'd0);
        do_access(1'b1, 32'h0000_0400, "R4");
        do_access(1'b0, 32'h0000_0480, "R4");

        // main sweep over all timing values
        for (int t = 1; t < 8; t++) begin
            write_ctl(2'd0);
            write_tim(3'(t));
            write_ctl(2'd2);
            base = 32'h0000_1000 + 32'(t) * 32'h100;
            for (int it = 0; it < 3; it++) begin
                for (int k = 0; k < 10; k++) begin
                    do_access(1'b1, base + 32'(4 * k), "");
                    if (k == 5) do_access(1'b0, 32'h0000_8000 + 32'(4 * it), "");
                end
            end
            // R7: line held only in prefetch buffer still misses on a jump
            do_access(1'b1, base + 32'h24, "R7");
            // R8: instruction line not visible to data reads
            do_access(1'b0, base, "R8");
            do_access(1'b0, base + 32'h4, "R8");
            // R9: control rewrite empties all buffers
            write_ctl(2'd2);
            do_access(1'b1, base + 32'h24, "R9");
            do_access(1'b0, base + 32'h4, "R9");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule